// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A request supplies the table base, the virtual address and a switch that allows the fine (1 KB granule) second-level tables. The block fetches the first-level entry. It then either finishes at once, for a 1 MB section or a fault, or fetches one second-level entry and finishes with a 64 KB, 4 KB or 1 KB page.

Each walk is launched by a one-cycle `start_i` while the block is idle. The block holds `busy_o` while it works. It issues word reads as one-cycle `mem_req_o` pulses with an address. It waits for `mem_valid_i` and flags a failed read with `mem_err_i`. It ends with a single `done_o` pulse. The physical address, the two-bit cacheable/bufferable attribute and the fault flag stay on the outputs until the next walk completes. Only one walk is in flight at a time.

Top module: `xlat_walker`

## Requirements
- R1: The first read address is {base[31:14], va[31:20], 2'b00}.
- R2: A first-level entry with bits [1:0] = 2 (section) completes after one read. The result is PA = {entry[31:20], va[19:0]}, attribute = entry[3:2] and no fault.
- R3: A first-level entry with bits [1:0] = 0 completes after one read with the fault flag set.
- R4: A first-level entry with bits [1:0] = 3 selects a fine table when `tiny_en_i` is 1. The second read address is then {entry[31:12], va[19:10], 2'b00}. When `tiny_en_i` is 0, the walk faults after one read.
- R5: A first-level entry with bits [1:0] = 1 selects a coarse table, with second read address {entry[31:10], va[19:12], 2'b00}.
- R6: A second-level entry with bits [1:0] = 1 gives PA = {entry[31:16], va[15:0]}.
- R7: A second-level entry with bits [1:0] = 2 gives PA = {entry[31:12], va[11:0]}.
- R8: A second-level entry with bits [1:0] = 3 gives PA = {entry[31:10], va[9:0]}.
- R9: For any page result, the attribute equals second-level entry bits [3:2].
- R10: A second-level entry with bits [1:0] = 0 ends the walk with the fault flag set.
- R11: A read answered with `mem_err_i` = 1, at either level, ends the walk at once with the fault flag set.
- R12: `busy_o` rises in the cycle after an accepted start. Each read is a one-cycle request. `done_o` is a one-cycle pulse after which `busy_o` is low. Result outputs change only in the `done_o` cycle.
- R13: A start while busy is ignored. Base, address and mode are captured at acceptance, so later changes to those inputs do not affect the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a walk (honoured when idle) |
| table_base_i | input | 32 | Translation table base |
| vaddr_i | input | 32 | Virtual address to translate |
| tiny_en_i | input | 1 | Allow fine second-level tables |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | One-cycle word read request |
| mem_addr_o | output | 32 | Read address |
| mem_valid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| mem_err_i | input | 1 | Read response error, qualified by valid |
| paddr_o | output | 32 | Translated physical address |
| attr_o | output | 2 | Cacheable/bufferable attribute |
| fault_o | output | 1 | Translation fault |

## Verification
The walk is driven with a section entry, with a coarse table ending in large and small pages, and with a fine table ending in a tiny page. Each uses a different virtual address, so an index taken from the wrong bit range shows up as a wrong read address or a wrong physical address. Fault paths are exercised separately: a level-one type 0, a type 3 with the fine mode off, a level-two type 0, and error responses at each level. The read count tells a walk that stops early from one that carries on. A final run changes every input and pulses start in the middle of a walk. It then confirms that both read addresses and the result still follow the values captured at launch.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int AW      = 32;
  localparam int TYPE_W  = 2;
  localparam int ATTR_W  = 2;
  localparam int BASE_LO = 14;  // first-level table alignment
  localparam int SEC_LO  = 20;  // section / first-level index position

  typedef enum logic [2:0] {
    WS_IDLE, WS_L1_REQ, WS_L1_WAIT, WS_L2_REQ, WS_L2_WAIT, WS_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    STEP_FAULT, STEP_LEAF, STEP_NEXT
  } step_e;

  function automatic logic [AW-1:0] l1_addr(input logic [AW-1:0] base,
                                            input logic [AW-1:0] va);
    return {base[AW-1:BASE_LO], va[AW-1:SEC_LO], 2'b00};
  endfunction

  function automatic logic [AW-1:0] coarse_addr(input logic [AW-1:0] d,
                                                input logic [AW-1:0] va);
    return {d[AW-1:10], va[19:12], 2'b00};
  endfunction

  function automatic logic [AW-1:0] fine_addr(input logic [AW-1:0] d,
                                              input logic [AW-1:0] va);
    return {d[AW-1:12], va[19:10], 2'b00};
  endfunction

  function automatic logic [AW-1:0] section_pa(input logic [AW-1:0] d,
                                               input logic [AW-1:0] va);
    return {d[AW-1:SEC_LO], va[SEC_LO-1:0]};
  endfunction

  function automatic logic [AW-1:0] large_pa(input logic [AW-1:0] d,
                                             input logic [AW-1:0] va);
    return {d[AW-1:16], va[15:0]};
  endfunction

  function automatic logic [AW-1:0] small_pa(input logic [AW-1:0] d,
                                             input logic [AW-1:0] va);
    return {d[AW-1:12], va[11:0]};
  endfunction

  function automatic logic [AW-1:0] tiny_pa(input logic [AW-1:0] d,
                                            input logic [AW-1:0] va);
    return {d[AW-1:10], va[9:0]};
  endfunction

endpackage

// File: rtl/xlat_decode.sv
module xlat_decode
  import xlat_pkg::*;
(
  input  logic              second_lvl,
  input  logic [AW-1:0]     entry,
  input  logic [AW-1:0]     va,
  input  logic              tiny_en,
  output step_e             step,
  output logic [AW-1:0]     next_addr,
  output logic [AW-1:0]     pa,
  output logic [ATTR_W-1:0] attr
);

  logic [TYPE_W-1:0] kind;
  assign kind = entry[TYPE_W-1:0];
  assign attr = entry[3:2];

  always_comb begin
    step      = STEP_FAULT;
    next_addr = '0;
    pa        = '0;
    if (!second_lvl) begin
      unique case (kind)
        2'd1: begin
          step      = STEP_NEXT;
          next_addr = coarse_addr(entry, va);
        end
        2'd2: begin
          step = STEP_LEAF;
          pa   = section_pa(entry, va);
        end
        2'd3: begin
          if (tiny_en) begin
            step      = STEP_NEXT;
            next_addr = fine_addr(entry, va);
          end
        end
        default: step = STEP_FAULT;
      endcase
    end else begin
      unique case (kind)
        2'd1: begin step = STEP_LEAF; pa = large_pa(entry, va); end
        2'd2: begin step = STEP_LEAF; pa = small_pa(entry, va); end
        2'd3: begin step = STEP_LEAF; pa = tiny_pa(entry, va);  end
        default: step = STEP_FAULT;
      endcase
    end
  end

endmodule

// File: rtl/xlat_fsm.sv
module xlat_fsm
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rsp_valid,
  input  logic        rsp_err,
  input  step_e       step,
  output walk_state_e state,
  output logic        accept,
  output logic        load_l2,
  output logic        finish,
  output logic        finish_fault
);

  walk_state_e nxt;
  logic        in_wait;

  assign in_wait      = (state == WS_L1_WAIT) || (state == WS_L2_WAIT);
  assign accept       = (state == WS_IDLE) && start;
  assign load_l2      = (state == WS_L1_WAIT) && rsp_valid && !rsp_err &&
                        (step == STEP_NEXT);
  assign finish       = in_wait && rsp_valid && !load_l2;
  assign finish_fault = rsp_err || (step == STEP_FAULT);

  always_comb begin
    nxt = state;
    unique case (state)
      WS_IDLE:    if (start) nxt = WS_L1_REQ;
      WS_L1_REQ:  nxt = WS_L1_WAIT;
      WS_L1_WAIT: if (load_l2) nxt = WS_L2_REQ;
                  else if (finish) nxt = WS_DONE;
      WS_L2_REQ:  nxt = WS_L2_WAIT;
      WS_L2_WAIT: if (finish) nxt = WS_DONE;
      WS_DONE:    nxt = WS_IDLE;
      default:    nxt = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= WS_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [31:0]   table_base_i,
  input  logic [31:0]   vaddr_i,
  input  logic          tiny_en_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic [31:0]   mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_err_i,
  output logic [31:0]   paddr_o,
  output logic [1:0]    attr_o,
  output logic          fault_o
);

  walk_state_e        state;
  step_e              step;
  logic               accept, load_l2, finish, finish_fault;
  logic [AW-1:0]      base_q, va_q, l2_addr_q;
  logic               tiny_q;
  logic [AW-1:0]      dec_next, dec_pa;
  logic [ATTR_W-1:0]  dec_attr;
  logic [AW-1:0]      pa_q;
  logic [ATTR_W-1:0]  attr_q;
  logic               fault_q;

  // named events for the checker
  logic sect_ev, l1_fault_ev, mem_err_ev;

  xlat_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_i),
    .rsp_valid(mem_valid_i), .rsp_err(mem_err_i), .step(step),
    .state(state), .accept(accept), .load_l2(load_l2),
    .finish(finish), .finish_fault(finish_fault)
  );

  xlat_decode u_dec (
    .second_lvl(state == WS_L2_WAIT), .entry(mem_rdata_i), .va(va_q),
    .tiny_en(tiny_q), .step(step), .next_addr(dec_next),
    .pa(dec_pa), .attr(dec_attr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      va_q      <= '0;
      tiny_q    <= 1'b0;
      l2_addr_q <= '0;
      pa_q      <= '0;
      attr_q    <= '0;
      fault_q   <= 1'b0;
    end else begin
      if (accept) begin
        base_q <= table_base_i;
        va_q   <= vaddr_i;
        tiny_q <= tiny_en_i;
      end
      if (load_l2) l2_addr_q <= dec_next;
      if (finish) begin
        fault_q <= finish_fault;
        pa_q    <= finish_fault ? '0 : dec_pa;
        attr_q  <= finish_fault ? '0 : dec_attr;
      end
    end
  end

  assign busy_o     = (state != WS_IDLE);
  assign done_o     = (state == WS_DONE);
  assign mem_req_o  = (state == WS_L1_REQ) || (state == WS_L2_REQ);
  assign mem_addr_o = (state == WS_L2_REQ) ? l2_addr_q : l1_addr(base_q, va_q);
  assign paddr_o    = pa_q;
  assign attr_o     = attr_q;
  assign fault_o    = fault_q;

  assign sect_ev     = (state == WS_L1_WAIT) && mem_valid_i && !mem_err_i &&
                       (step == STEP_LEAF);
  assign l1_fault_ev = (state == WS_L1_WAIT) && mem_valid_i && !mem_err_i &&
                       (step == STEP_FAULT);
  assign mem_err_ev  = ((state == WS_L1_WAIT) || (state == WS_L2_WAIT)) &&
                       mem_valid_i && mem_err_i;

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        mem_req_o,
  input logic [31:0] paddr_o,
  input logic        fault_o,
  input logic        sect_ev,
  input logic        l1_fault_ev,
  input logic        mem_err_ev
);

  // R2
  sect_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sect_ev |=> done_o && !fault_o && !mem_req_o);

  // R3
  l1_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_fault_ev |=> done_o && fault_o && !mem_req_o);

  // R11
  mem_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_err_ev |=> done_o && fault_o);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  // R12
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o && busy_o);

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(paddr_o) |-> done_o);

  // R13
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o && mem_req_o);

endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .mem_req_o(mem_req_o), .paddr_o(paddr_o),
  .fault_o(fault_o), .sect_ev(sect_ev), .l1_fault_ev(l1_fault_ev),
  .mem_err_ev(mem_err_ev)
);

// File: tb/xlat_walker_test.sv
module xlat_walker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] table_base_i = '0;
  logic [31:0] vaddr_i = '0;
  logic        tiny_en_i = 1'b0;
  logic        busy_o, done_o, mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_err_i = 1'b0;
  logic [31:0] paddr_o;
  logic [1:0]  attr_o;
  logic        fault_o;

  int checks = 0;
  int errors = 0;

  // memory responder state
  logic [31:0] rsp_data [4];
  logic        rsp_err  [4];
  logic [31:0] req_addr [4];
  int          nreq = 0;
  int          ridx = 0;
  int          delay_cnt = 0;

  always #4 clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .table_base_i(table_base_i),
    .vaddr_i(vaddr_i), .tiny_en_i(tiny_en_i), .busy_o(busy_o), .done_o(done_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i),
    .mem_rdata_i(mem_rdata_i), .mem_err_i(mem_err_i), .paddr_o(paddr_o),
    .attr_o(attr_o), .fault_o(fault_o)
  );

  always @(negedge clk) begin
    mem_valid_i = 1'b0;
    mem_err_i   = 1'b0;
    if (delay_cnt == 1 && ridx < 4) begin
      mem_valid_i = 1'b1;
      mem_rdata_i = rsp_data[ridx];
      mem_err_i   = rsp_err[ridx];
      ridx++;
    end
    if (delay_cnt > 0) delay_cnt--;
    if (mem_req_o) begin
      if (nreq < 4) req_addr[nreq] = mem_addr_o;
      nreq++;
      delay_cnt = 2;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // expected values written with masks and shifts
  function automatic logic [31:0] e_l1(input logic [31:0] b, input logic [31:0] v);
    return (b & 32'hFFFF_C000) | ((v >> 20) << 2);
  endfunction
  function automatic logic [31:0] e_coarse(input logic [31:0] d, input logic [31:0] v);
    return (d & 32'hFFFF_FC00) | (((v >> 12) & 32'hFF) << 2);
  endfunction
  function automatic logic [31:0] e_fine(input logic [31:0] d, input logic [31:0] v);
    return (d & 32'hFFFF_F000) | (((v >> 10) & 32'h3FF) << 2);
  endfunction

  // run one walk; disturb=1 changes inputs and pulses start mid-walk
  task automatic walk(input logic [31:0] b, input logic [31:0] v, input logic t,
                      input logic [31:0] d1, input logic e1,
                      input logic [31:0] d2, input logic e2, input logic disturb);
    int n;
    nreq = 0; ridx = 0;
    rsp_data[0] = d1; rsp_err[0] = e1;
    rsp_data[1] = d2; rsp_err[1] = e2;
    rsp_data[2] = 32'h0; rsp_err[2] = 1'b0;
    rsp_data[3] = 32'h0; rsp_err[3] = 1'b0;
    @(negedge clk);
    table_base_i = b; vaddr_i = v; tiny_en_i = t; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R12 busy after start", {31'b0, busy_o}, 32'd1);
    if (disturb) begin
      table_base_i = ~b; vaddr_i = ~v; tiny_en_i = ~t;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk("R12 done reached", {31'b0, done_o}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R12 reset busy", {31'b0, busy_o}, 32'd0);
    chk("R12 reset done", {31'b0, done_o}, 32'd0);
    chk("R12 reset req", {31'b0, mem_req_o}, 32'd0);
    chk("R12 reset fault", {31'b0, fault_o}, 32'd0);
    chk("R12 reset paddr", paddr_o, 32'd0);
  endtask

  task automatic t_section();
    walk(32'h1234_5FFF, 32'hABC1_2345, 1'b0, 32'h5670_000E, 1'b0, 32'h0, 1'b0, 1'b0);
    chk("R1 l1 address", req_addr[0], e_l1(32'h1234_5FFF, 32'hABC1_2345));
    chk("R2 one read", nreq, 32'd1);
    chk("R2 section pa", paddr_o, (32'h5670_000E & 32'hFFF0_0000) | (32'hABC1_2345 & 32'h000F_FFFF));
    chk("R2 attr", {30'b0, attr_o}, 32'd3);
    chk("R2 no fault", {31'b0, fault_o}, 32'd0);
  endtask

  task automatic t_l1_fault();
    walk(32'h0000_4000, 32'h0010_0000, 1'b1, 32'hFFFF_FFFC, 1'b0, 32'h0, 1'b0, 1'b0);
    chk("R3 fault", {31'b0, fault_o}, 32'd1);
    chk("R3 one read", nreq, 32'd1);
    walk(32'h0000_8000, 32'h0030_0000, 1'b0, 32'h0040_0003, 1'b0, 32'h0000_0FFE, 1'b0, 1'b0);
    chk("R4 fine disabled fault", {31'b0, fault_o}, 32'd1);
    chk("R4 fine disabled one read", nreq, 32'd1);
  endtask

  task automatic t_coarse_small();
    logic [31:0] v = 32'h89AB_CDEF;
    logic [31:0] d1 = 32'h0008_0401;
    logic [31:0] d2 = 32'h4444_5006;
    walk(32'h0002_0000, v, 1'b0, d1, 1'b0, d2, 1'b0, 1'b0);
    chk("R5 coarse address", req_addr[1], e_coarse(d1, v));
    chk("R7 small pa", paddr_o, (d2 & 32'hFFFF_F000) | (v & 32'hFFF));
    chk("R9 attr small", {30'b0, attr_o}, 32'd1);
    chk("R7 two reads", nreq, 32'd2);
  endtask

  task automatic t_coarse_large();
    logic [31:0] v = 32'h1357_9BDF;
    logic [31:0] d1 = 32'hCAFE_B801;
    logic [31:0] d2 = 32'h7777_8009;
    walk(32'h0004_0000, v, 1'b1, d1, 1'b0, d2, 1'b0, 1'b0);
    chk("R5 coarse address 2", req_addr[1], e_coarse(d1, v));
    chk("R6 large pa", paddr_o, (d2 & 32'hFFFF_0000) | (v & 32'hFFFF));
    chk("R9 attr large", {30'b0, attr_o}, 32'd2);
  endtask

  task automatic t_fine_tiny();
    logic [31:0] v = 32'h2468_ACE1;
    logic [31:0] d1 = 32'h1111_2003;
    logic [31:0] d2 = 32'h9ABC_DE0F;
    walk(32'h0006_0000, v, 1'b1, d1, 1'b0, d2, 1'b0, 1'b0);
    chk("R4 fine address", req_addr[1], e_fine(d1, v));
    chk("R8 tiny pa", paddr_o, (d2 & 32'hFFFF_FC00) | (v & 32'h3FF));
    chk("R9 attr tiny", {30'b0, attr_o}, 32'd3);
    chk("R8 no fault", {31'b0, fault_o}, 32'd0);
  endtask

  task automatic t_l2_fault();
    walk(32'h0008_0000, 32'h0000_1000, 1'b0, 32'h0000_0401, 1'b0, 32'hFFFF_FFFC, 1'b0, 1'b0);
    chk("R10 l2 fault", {31'b0, fault_o}, 32'd1);
    chk("R10 two reads", nreq, 32'd2);
  endtask

  task automatic t_mem_err();
    walk(32'h000A_0000, 32'h0050_0000, 1'b0, 32'h5000_0002, 1'b1, 32'h0, 1'b0, 1'b0);
    chk("R11 l1 error fault", {31'b0, fault_o}, 32'd1);
    chk("R11 l1 error one read", nreq, 32'd1);
    walk(32'h000C_0000, 32'h0060_0000, 1'b0, 32'h0000_0801, 1'b0, 32'h1234_5002, 1'b1, 1'b0);
    chk("R11 l2 error fault", {31'b0, fault_o}, 32'd1);
    chk("R11 l2 error two reads", nreq, 32'd2);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v = 32'h3579_BDF1;
    logic [31:0] b = 32'h00E0_0000;
    logic [31:0] d1 = 32'h0012_3401;
    logic [31:0] d2 = 32'h5555_A00A;
    walk(b, v, 1'b0, d1, 1'b0, d2, 1'b0, 1'b1);
    chk("R13 l1 address captured", req_addr[0], e_l1(b, v));
    chk("R13 l2 address captured", req_addr[1], e_coarse(d1, v));
    chk("R13 pa from captured va", paddr_o, (d2 & 32'hFFFF_F000) | (v & 32'hFFF));
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R13 no extra walk", nreq, 32'd2);
    chk("R12 idle after done", {31'b0, busy_o}, 32'd0);
    chk("R12 done single pulse", {31'b0, done_o}, 32'd0);
    chk("R12 result held", paddr_o, (d2 & 32'hFFFF_F000) | (v & 32'hFFF));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_section();
    t_l1_fault();
    t_coarse_small();
    t_coarse_large();
    t_fine_tiny();
    t_l2_fault();
    t_mem_err();
    t_busy_ignore();
    summary();
  end

endmodule